// File: doc/BRIEF.md
# Slow-Idle Clock Enable Divider

This block places a processor core into an idle state on command and, when asked, slows the core's clock while it waits. Rather than gating a clock tree, it produces clock-enable strobes. One strobe is for the core and one each is for three derived domains: the serial clock, the clock output and the timer tick. The idle command carries a two-bit divisor code that selects a period of 16, 32, 64 or 128 cycles. A separate flag asks for plain idle instead, where the clock keeps its full rate.

While in divided idle, a counter produces one core strobe every n cycles. Each derived domain strobe is a sub-multiple of the core strobe, so every domain slows by the same ratio. A pending enabled interrupt ends idle, but in divided idle the block only looks at it on a core strobe, so the wake latency can be up to n cycles. In plain idle the block answers in one cycle. When idle ends, the divide counter clears and all strobes return to full rate on the next cycle. A one-cycle resume pulse tells the core to go on with the instruction after the idle command. Cycle-steal requests from DMA and autobuffering are granted in every state, idle included.

Top module: `slow_idle_clkdiv`

## Requirements
- R1: While reset is asserted, idle_active, slow_active, resume and steal_gnt are 0 and core_en is 1.
- R2: Outside divided idle, core_en is 1 on every cycle.
- R3: An idle_cmd pulse while not idle, with plain_idle=1, sets idle_active on the next cycle with slow_active=0, and core_en stays 1.
- R4: In plain idle, irq_pending=1 on a cycle clears idle_active on the next cycle.
- R5: An idle_cmd pulse with plain_idle=0 enters divided idle with period n = 16 << div_code (00=16, 01=32, 10=64, 11=128). core_en then pulses once every n cycles, first on the n-th idle cycle.
- R6: sclk_en, clkout_en and timer_en fire only on core_en cycles, on every 2nd, every 1st and every 4th core_en pulse respectively (default pre-scales), counted from reset.
- R7: In divided idle, idle_active clears only on the cycle after a core_en pulse that coincided with irq_pending=1. The latency from a held interrupt to the exit is therefore at most n cycles.
- R8: resume is 1 for exactly the first cycle after idle_active falls, and 0 otherwise.
- R9: After divided idle ends, core_en is 1 on every following cycle until idle is entered again.
- R10: idle_cmd, div_code and plain_idle are ignored while idle_active is 1; the running period is unchanged.
- R11: steal_gnt equals steal_req delayed by one cycle, in every state.
- R12: irq_pending has no effect while not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_cmd | input | 1 | One-cycle idle command |
| div_code | input | 2 | Divisor code sampled with idle_cmd |
| plain_idle | input | 1 | Selects undivided idle |
| irq_pending | input | 1 | An enabled interrupt is pending |
| steal_req | input | 1 | DMA/autobuffer cycle-steal request |
| core_en | output | 1 | Core clock enable strobe |
| sclk_en | output | 1 | Serial clock enable strobe |
| clkout_en | output | 1 | Clock-out enable strobe |
| timer_en | output | 1 | Timer tick enable strobe |
| idle_active | output | 1 | Core is idle |
| slow_active | output | 1 | Idle with divided clock |
| resume | output | 1 | First cycle back in run |
| steal_gnt | output | 1 | Cycle-steal grant |

## Verification
The main function is tried with four kinds of input pattern, and each one separates different faults:
- Random mixes of idle commands, codes, the plain flag, short and held interrupts and steal requests. These separate a wrong period or encoding from a wrong wake rule, because a short interrupt that misses a core pulse must not wake a divided idle.
- An interrupt raised at a random offset inside the period for every code. This pins the exact wake latency, n minus the offset, which exposes off-by-one counters.
- A fresh idle command issued in the middle of divided idle. This shows whether the running period is disturbed.
- Interrupts given while running. These show that the interrupt input has no effect outside idle.

// File: rtl/sidl_pkg.sv
package sidl_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STD  = 2'd1,
    ST_SLOW = 2'd2
  } sidl_state_e;

  // Divided-idle period for a divisor code: base period shifted by the code.
  function automatic logic [31:0] sidl_period(input logic [31:0] code,
                                              input int unsigned base_shift);
    return 32'd1 << (base_shift + code);
  endfunction

  // Counter width able to hold the largest period minus one.
  function automatic int unsigned sidl_cnt_width(input int unsigned base_shift,
                                                 input int unsigned code_w);
    return base_shift + (1 << code_w) - 1;
  endfunction

  // Width for a prescale counter of the given ratio (at least one bit).
  function automatic int unsigned sidl_pre_width(input int unsigned pre);
    return (pre > 1) ? $clog2(pre) : 1;
  endfunction

endpackage

// File: rtl/sidl_ctrl.sv
module sidl_ctrl
  import sidl_pkg::*;
#(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_cmd,
  input  logic [CODE_W-1:0] div_code,
  input  logic              plain_idle,
  input  logic              irq_pending,
  input  logic              tick,
  output logic              idle_q,
  output logic              slow_q,
  output logic [CODE_W-1:0] code_q,
  output logic              enter,
  output logic              wake,
  output logic              resume_q
);

  sidl_state_e state_q, state_d;
  logic [CODE_W-1:0] code_d;

  assign idle_q = (state_q != ST_RUN);
  assign slow_q = (state_q == ST_SLOW);

  // Entry only from run; wake needs a pending interrupt and, in divided
  // idle, a core strobe on the same cycle.
  assign enter = (state_q == ST_RUN) && idle_cmd;
  assign wake  = irq_pending &&
                 ((state_q == ST_STD) || ((state_q == ST_SLOW) && tick));

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (enter) begin
      state_d = plain_idle ? ST_STD : ST_SLOW;
      code_d  = div_code;
    end else if (wake) begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      code_q   <= '0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      code_q   <= code_d;
      resume_q <= wake;
    end
  end

endmodule

// File: rtl/sidl_divcnt.sv
module sidl_divcnt
  import sidl_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 4,
  parameter int unsigned CODE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic [31:0]       period,
  output logic              tick
);

  localparam int unsigned CNT_W = sidl_cnt_width(BASE_SHIFT, CODE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign period = sidl_period(32'(code), BASE_SHIFT);
  assign last   = CNT_W'(period - 32'd1);
  assign tick   = run && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sidl_domain.sv
module sidl_domain
  import sidl_pkg::*;
#(
  parameter int unsigned PRE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_tick,
  output logic dom_en
);

  localparam int unsigned PW = sidl_pre_width(PRE);

  generate
    if (PRE <= 1) begin : g_pass
      assign dom_en = core_tick;
    end else begin : g_pre
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap   = (pre_q == PW'(PRE - 1));
      assign dom_en = core_tick && wrap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (core_tick) begin
          pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/slow_idle_clkdiv.sv
module slow_idle_clkdiv
  import sidl_pkg::*;
#(
  parameter int unsigned BASE_SHIFT = 4,
  parameter int unsigned CODE_W     = 2,
  parameter int unsigned SCLK_PRE   = 2,
  parameter int unsigned CLKO_PRE   = 1,
  parameter int unsigned TMR_PRE    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_cmd,
  input  logic [CODE_W-1:0] div_code,
  input  logic              plain_idle,
  input  logic              irq_pending,
  input  logic              steal_req,
  output logic              core_en,
  output logic              sclk_en,
  output logic              clkout_en,
  output logic              timer_en,
  output logic              idle_active,
  output logic              slow_active,
  output logic              resume,
  output logic              steal_gnt
);

  localparam int unsigned NDOM = 3;
  localparam int unsigned PRE_TAB [NDOM] = '{SCLK_PRE, CLKO_PRE, TMR_PRE};

  logic              idle_w;
  logic              slow_w;
  logic [CODE_W-1:0] code_w;
  logic              enter_w;
  logic              wake_w;
  logic              tick_w;
  logic [31:0]       period_w;
  logic [NDOM-1:0]   dom_w;
  logic              steal_q;

  sidl_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_cmd    (idle_cmd),
    .div_code    (div_code),
    .plain_idle  (plain_idle),
    .irq_pending (irq_pending),
    .tick        (tick_w),
    .idle_q      (idle_w),
    .slow_q      (slow_w),
    .code_q      (code_w),
    .enter       (enter_w),
    .wake        (wake_w),
    .resume_q    (resume)
  );

  sidl_divcnt #(.BASE_SHIFT(BASE_SHIFT), .CODE_W(CODE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (slow_w),
    .clr    (enter_w | wake_w),
    .code   (code_w),
    .period (period_w),
    .tick   (tick_w)
  );

  // Full rate unless divided idle is active.
  assign core_en = !slow_w || tick_w;

  for (genvar i = 0; i < NDOM; i++) begin : g_dom
    sidl_domain #(.PRE(PRE_TAB[i])) u_dom (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_tick (core_en),
      .dom_en    (dom_w[i])
    );
  end

  // Cycle steals are served regardless of idle state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) steal_q <= 1'b0;
    else        steal_q <= steal_req;
  end

  assign steal_gnt   = steal_q;
  assign sclk_en     = dom_w[0];
  assign clkout_en   = dom_w[1];
  assign timer_en    = dom_w[2];
  assign idle_active = idle_w;
  assign slow_active = slow_w;

endmodule

// File: rtl/sidl_checker.sv
module sidl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_pending,
  input logic        steal_req,
  input logic        core_en,
  input logic        sclk_en,
  input logic        clkout_en,
  input logic        timer_en,
  input logic        idle_active,
  input logic        slow_active,
  input logic        resume,
  input logic        steal_gnt,
  input logic        wake_w,
  input logic [31:0] period_w
);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!idle_active && !slow_active && !resume && !steal_gnt));

  a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_active |-> core_en);

  a_r4_plain_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_active && !slow_active && irq_pending) |=> !idle_active);

  a_r6_dom_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en || clkout_en || timer_en) |-> core_en);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && !core_en) |=> idle_active);

  a_r7_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && core_en && irq_pending) |=> (!idle_active && resume));

  a_r8_resume_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_active) |-> resume);

  a_r8_resume_only: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !idle_active);

  a_r10_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_active && !wake_w) |=> (slow_active && $stable(period_w)));

  a_r11_steal: assert property (@(posedge clk) disable iff (!rst_n)
    steal_req |=> steal_gnt);

endmodule

bind slow_idle_clkdiv sidl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_pending (irq_pending),
  .steal_req   (steal_req),
  .core_en     (core_en),
  .sclk_en     (sclk_en),
  .clkout_en   (clkout_en),
  .timer_en    (timer_en),
  .idle_active (idle_active),
  .slow_active (slow_active),
  .resume      (resume),
  .steal_gnt   (steal_gnt),
  .wake_w      (wake_w),
  .period_w    (period_w)
);

// File: tb/slow_idle_clkdiv_test.sv
module slow_idle_clkdiv_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle_cmd = 1'b0;
  logic [1:0] div_code = 2'd0;
  logic       plain_idle = 1'b0;
  logic       irq_pending = 1'b0;
  logic       steal_req = 1'b0;
  logic core_en, sclk_en, clkout_en, timer_en;
  logic idle_active, slow_active, resume, steal_gnt;

  always #5 clk = ~clk;

  slow_idle_clkdiv uut (
    .clk(clk), .rst_n(rst_n), .idle_cmd(idle_cmd), .div_code(div_code),
    .plain_idle(plain_idle), .irq_pending(irq_pending), .steal_req(steal_req),
    .core_en(core_en), .sclk_en(sclk_en), .clkout_en(clkout_en),
    .timer_en(timer_en), .idle_active(idle_active), .slow_active(slow_active),
    .resume(resume), .steal_gnt(steal_gnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state, built from the requirements.
  bit m_idle, m_slow, m_resume, m_steal;
  int m_n, m_pos;
  int m_pre [3];
  int pre_ratio [3] = '{2, 1, 4};

  function automatic int period_of(int code);
    case (code)
      0: return 16;
      1: return 32;
      2: return 64;
      default: return 128;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_idle = 0; m_slow = 0; m_resume = 0; m_steal = 0;
    m_n = 16; m_pos = 0;
    foreach (m_pre[i]) m_pre[i] = 0;
  endtask

  // Checks the current cycle, advances the model, moves to the next cycle.
  task automatic step();
    bit ex_core, wake;
    int dom_act [3];
    #1;
    ex_core = !m_slow || (m_pos == m_n - 1);
    dom_act[0] = int'(sclk_en); dom_act[1] = int'(clkout_en);
    dom_act[2] = int'(timer_en);
    chk(m_slow ? "R5" : "R2", "core_en", int'(core_en), int'(ex_core));
    for (int i = 0; i < 3; i++)
      chk("R6", "domain enable", dom_act[i],
          int'(ex_core && (m_pre[i] == pre_ratio[i] - 1)));
    chk("R3", "idle_active", int'(idle_active), int'(m_idle));
    chk("R5", "slow_active", int'(slow_active), int'(m_slow));
    chk("R8", "resume", int'(resume), int'(m_resume));
    chk("R11", "steal_gnt", int'(steal_gnt), int'(m_steal));
    wake = m_idle && irq_pending && (!m_slow || ex_core);
    m_steal  = steal_req;
    m_resume = wake;
    if (ex_core)
      for (int i = 0; i < 3; i++)
        m_pre[i] = (m_pre[i] == pre_ratio[i] - 1) ? 0 : m_pre[i] + 1;
    if (!m_idle && idle_cmd) begin
      m_idle = 1; m_slow = !plain_idle; m_n = period_of(int'(div_code));
      m_pos = 0;
    end else if (wake) begin
      m_idle = 0; m_slow = 0; m_pos = 0;
    end else if (m_slow) begin
      m_pos = ex_core ? 0 : m_pos + 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lat, j, n, idx;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "idle_active in reset", int'(idle_active), 0);
    chk("R1", "slow_active in reset", int'(slow_active), 0);
    chk("R1", "resume in reset", int'(resume), 0);
    chk("R1", "steal_gnt in reset", int'(steal_gnt), 0);
    chk("R1", "core_en in reset", int'(core_en), 1);
    rst_n = 1'b1;
    model_reset();

    // R12: interrupt while running does nothing
    irq_pending = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk("R12", "idle_active with irq in run", int'(idle_active), 0);
      chk("R12", "core_en with irq in run", int'(core_en), 1);
      step();
    end
    irq_pending = 1'b0;

    // R3 / R4: plain idle and one-cycle wake
    idle_cmd = 1'b1; plain_idle = 1'b1; div_code = 2'd3;
    step();
    idle_cmd = 1'b0; plain_idle = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R3", "plain idle entered", int'(idle_active), 1);
      chk("R3", "plain idle full rate", int'(core_en), 1);
      step();
    end
    irq_pending = 1'b1;
    step();
    irq_pending = 1'b0;
    chk("R4", "plain idle exit next cycle", int'(idle_active), 0);
    step();

    // R7 / R9: exact wake latency per code
    for (int c = 0; c < 4; c++) begin
      n = period_of(c);
      j = int'($urandom % n);
      idle_cmd = 1'b1; div_code = 2'(c);
      step();
      idle_cmd = 1'b0;
      repeat (j) step();
      irq_pending = 1'b1;
      lat = 0;
      while (idle_active && lat < 300) begin
        step();
        lat++;
      end
      irq_pending = 1'b0;
      chk("R7", "wake latency", lat, n - j);
      chk("R7", "latency within period", int'(lat <= n), 1);
      for (int k = 0; k < 4; k++) begin
        chk("R9", "full rate after slow idle", int'(core_en), 1);
        step();
      end
    end

    // R10: second idle command during divided idle is ignored
    idle_cmd = 1'b1; plain_idle = 1'b0; div_code = 2'd0;
    step();
    idle_cmd = 1'b0;
    repeat (5) step();
    idle_cmd = 1'b1; plain_idle = 1'b1; div_code = 2'd3;
    step();
    idle_cmd = 1'b0; plain_idle = 1'b0; div_code = 2'd0;
    idx = 6;
    while (!core_en && idx < 300) begin
      step();
      idx++;
    end
    chk("R10", "first pulse index after ignored command", idx, 15);
    chk("R10", "still divided idle", int'(slow_active), 1);
    irq_pending = 1'b1;
    while (idle_active) step();
    irq_pending = 1'b0;
    step();

    // Random mix
    for (int k = 0; k < 12000; k++) begin
      idle_cmd    = ($urandom % 24) == 0;
      div_code    = 2'($urandom % 4);
      plain_idle  = ($urandom % 4) == 0;
      irq_pending = ($urandom % 10) == 0;
      steal_req   = ($urandom % 2) == 1;
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule